// File: doc/BRIEF.md
# Two-Master Shared-Slave Bus Arbiter

This block lets two bus masters share one slave on a pipelined address/data bus, where each transfer's write data follows its address by one cycle. Each master raises a request line and gets back a grant line. The arbiter keeps track of who owns the address phase and who owns the data phase as two separate registers. It steers the owning master's address, write flag and write data to the slave.

Grants are worked out combinationally from the two requests and the current address owner. The address-phase select is loaded from the grant on the next clock edge, because a master only starts driving its address once it has seen its grant. The data-phase select is the address-phase select delayed by one more clock edge. Both selects freeze while the slave holds its ready input low, so a stalled address and its stalled write data stay on the bus.

Top module: `bus_arb2`

## Requirements
- R1: Reset is synchronous and active high. It forces both grants low and both owner outputs to 2'b00 (no master), even while requests are asserted. It also forces the slave address, write flag and write data to zero.
- R2: At most one grant is high in any cycle. A lone requester gets its grant combinationally, in the same cycle as its request, when the bus is idle and the slave is ready.
- R3: When both masters request in the same cycle and no master owns the address phase, master 1 is granted.
- R4: A master that owns the address phase keeps its grant for as long as its request stays high, even if the other master requests. The other master is granted in the cycle in which the owner's request drops.
- R5: When the slave is ready, `addr_owner` on the following cycle equals the grant vector {m2_grant, m1_grant} of the current cycle. The encoding is 2'b01 for master 1, 2'b10 for master 2 and 2'b00 for no master, and `data_owner` uses the same encoding.
- R6: When the slave is ready, `data_owner` on the following cycle equals the current `addr_owner`. `s_wdata` carries the write data of the master named by `data_owner`.
- R7: While `s_ready` is low, both owner outputs hold their values across the clock edge. The grant vector then equals `addr_owner`, whatever the requests are.
- R8: When `addr_owner` is 2'b00, `s_addr` and `s_write` are zero. When `data_owner` is 2'b00, `s_wdata` is zero.
- R9: `s_addr` and `s_write` carry the address and write flag of the master named by `addr_owner`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m1_req | input | 1 | Bus request from master 1 |
| m1_addr | input | ADDR_W | Address from master 1 |
| m1_write | input | 1 | Write flag from master 1 |
| m1_wdata | input | DATA_W | Write data from master 1 |
| m1_grant | output | 1 | Grant to master 1 |
| m2_req | input | 1 | Bus request from master 2 |
| m2_addr | input | ADDR_W | Address from master 2 |
| m2_write | input | 1 | Write flag from master 2 |
| m2_wdata | input | DATA_W | Write data from master 2 |
| m2_grant | output | 1 | Grant to master 2 |
| s_ready | input | 1 | Slave ready; low stalls the bus |
| s_addr | output | ADDR_W | Address to the slave |
| s_write | output | 1 | Write flag to the slave |
| s_wdata | output | DATA_W | Write data to the slave |
| addr_owner | output | 2 | Address-phase owner (01 = master 1, 10 = master 2, 00 = none) |
| data_owner | output | 2 | Data-phase owner, same encoding |

## Verification
The bench drives a handover in which the owner drops its request while the other master is waiting. A design that preempts would move the grant early. One that forgets ownership would hand the bus to master 1 on every tie. The bench stalls the slave in the middle of a handover and checks that both owners and the grant stay put. A design that let either select advance would put the wrong write data on the bus. The cycle in which the address owner goes idle while the data owner still holds the other master's data is checked separately, because sharing one select between both paths fails exactly there. Reset is applied with requests held high, at start-up and again in the middle of a run.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    // One-hot ownership code; 2'b00 means no master.
    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_M1   = 2'b01,
        OWN_M2   = 2'b10
    } owner_e;

    // Owner keeps the bus while requesting; otherwise master 1 has priority.
    function automatic owner_e pick_owner(input logic req1, input logic req2,
                                          input owner_e cur);
        owner_e res;
        if (cur == OWN_M1 && req1)      res = OWN_M1;
        else if (cur == OWN_M2 && req2) res = OWN_M2;
        else if (req1)                  res = OWN_M1;
        else if (req2)                  res = OWN_M2;
        else                            res = OWN_NONE;
        return res;
    endfunction

endpackage

// File: rtl/arb_owner_ctrl.sv
module arb_owner_ctrl
    import bus_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       ready,
    output logic [1:0] grant,
    output owner_e     addr_sel,
    output owner_e     data_sel
);

    owner_e next_owner;

    always_comb begin
        if (rst)
            next_owner = OWN_NONE;
        else if (ready)
            next_owner = pick_owner(req[0], req[1], addr_sel);
        else
            next_owner = addr_sel;
        grant = 2'(next_owner);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_sel <= OWN_NONE;
            data_sel <= OWN_NONE;
        end else if (ready) begin
            addr_sel <= next_owner;
            data_sel <= addr_sel;
        end
    end

    // R2: never two grants
    p_grant_onehot_r2: assert property (@(posedge clk) $onehot0(grant));

    // R4: no preemption of a requesting owner
    p_no_preempt_r4: assert property (@(posedge clk) disable iff (rst)
        ((addr_sel == OWN_M1 && req[0]) || (addr_sel == OWN_M2 && req[1]))
        |-> (grant == 2'(addr_sel)));

    // R6: data owner trails address owner by one ready cycle
    p_data_trails_r6: assert property (@(posedge clk) disable iff (rst)
        ready |=> (data_sel == $past(addr_sel)));

    // R7: stall freezes both selects
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ready |=> ($stable(addr_sel) && $stable(data_sel)));

endmodule

// File: rtl/arb_path_mux.sv
module arb_path_mux
    import bus_arb_pkg::*;
#(
    parameter int W = 32
) (
    input  owner_e         sel,
    input  logic [W-1:0]   in_m1,
    input  logic [W-1:0]   in_m2,
    output logic [W-1:0]   out
);

    always_comb begin
        unique case (sel)
            OWN_M1:  out = in_m1;
            OWN_M2:  out = in_m2;
            default: out = '0;
        endcase
    end

endmodule

// File: rtl/bus_arb2.sv
module bus_arb2
    import bus_arb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m1_req,
    input  logic [ADDR_W-1:0] m1_addr,
    input  logic              m1_write,
    input  logic [DATA_W-1:0] m1_wdata,
    output logic              m1_grant,
    input  logic              m2_req,
    input  logic [ADDR_W-1:0] m2_addr,
    input  logic              m2_write,
    input  logic [DATA_W-1:0] m2_wdata,
    output logic              m2_grant,
    input  logic              s_ready,
    output logic [ADDR_W-1:0] s_addr,
    output logic              s_write,
    output logic [DATA_W-1:0] s_wdata,
    output logic [1:0]        addr_owner,
    output logic [1:0]        data_owner
);

    localparam int CTRL_W = ADDR_W + 1;

    logic [1:0]        grant_vec;
    owner_e            a_sel;
    owner_e            d_sel;
    logic [CTRL_W-1:0] ctrl_out;

    arb_owner_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req      ({m2_req, m1_req}),
        .ready    (s_ready),
        .grant    (grant_vec),
        .addr_sel (a_sel),
        .data_sel (d_sel)
    );

    arb_path_mux #(.W(CTRL_W)) u_addr_mux (
        .sel   (a_sel),
        .in_m1 ({m1_write, m1_addr}),
        .in_m2 ({m2_write, m2_addr}),
        .out   (ctrl_out)
    );

    arb_path_mux #(.W(DATA_W)) u_wdata_mux (
        .sel   (d_sel),
        .in_m1 (m1_wdata),
        .in_m2 (m2_wdata),
        .out   (s_wdata)
    );

    assign m1_grant   = grant_vec[0];
    assign m2_grant   = grant_vec[1];
    assign s_write    = ctrl_out[CTRL_W-1];
    assign s_addr     = ctrl_out[ADDR_W-1:0];
    assign addr_owner = 2'(a_sel);
    assign data_owner = 2'(d_sel);

    // R1: reset holds grants low
    p_reset_nogrant_r1: assert property (@(posedge clk)
        rst |-> (!m1_grant && !m2_grant));

    // R5: address owner follows the previous grant
    p_addr_follows_grant_r5: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> (addr_owner == $past({m2_grant, m1_grant})));

    // R8: idle address phase drives zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (addr_owner == 2'b00) |-> (s_addr == '0 && !s_write));

    // R9: address steering from master 2
    p_addr_steer_r9: assert property (@(posedge clk) disable iff (rst)
        (addr_owner == 2'b10) |-> (s_addr == m2_addr && s_write == m2_write));

endmodule

// File: tb/bus_arb2_test.sv
module bus_arb2_test;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [AW-1:0] A1 = 32'h1000_0001;
    localparam logic [AW-1:0] A2 = 32'h2000_0002;
    localparam logic [DW-1:0] D1 = 32'hA1A1_A1A1;
    localparam logic [DW-1:0] D2 = 32'hB2B2_B2B2;
    localparam int NV = 14;

    // {r1, r2, ready, grant{g2,g1}, addr_owner, data_owner after edge}
    localparam logic [8:0] VEC [NV] = '{
        {3'b001, 2'b00, 2'b00, 2'b00},  // idle (R8)
        {3'b011, 2'b10, 2'b10, 2'b00},  // master 2 alone (R2)
        {3'b111, 2'b10, 2'b10, 2'b10},  // owner m2 holds (R4)
        {3'b101, 2'b01, 2'b01, 2'b10},  // m2 drops, hand-off (R4)
        {3'b110, 2'b01, 2'b01, 2'b10},  // stall (R7)
        {3'b010, 2'b01, 2'b01, 2'b10},  // stall, owner dropped (R7)
        {3'b011, 2'b10, 2'b10, 2'b01},  // resume (R5 R6)
        {3'b001, 2'b00, 2'b00, 2'b10},  // addr idle, data m2 (R8)
        {3'b001, 2'b00, 2'b00, 2'b00},
        {3'b111, 2'b01, 2'b01, 2'b00},  // tie idle (R3)
        {3'b001, 2'b00, 2'b00, 2'b01},
        {3'b001, 2'b00, 2'b00, 2'b00},
        {3'b101, 2'b01, 2'b01, 2'b00},  // master 1 alone (R2)
        {3'b001, 2'b00, 2'b00, 2'b01}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m1_req = 1'b1, m2_req = 1'b1, s_ready = 1'b1;
    logic m1_grant, m2_grant, s_write;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata;
    logic [1:0] addr_owner, data_owner;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_arb2 #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .m1_req(m1_req), .m1_addr(A1), .m1_write(1'b1), .m1_wdata(D1), .m1_grant(m1_grant),
        .m2_req(m2_req), .m2_addr(A2), .m2_write(1'b0), .m2_wdata(D2), .m2_grant(m2_grant),
        .s_ready(s_ready), .s_addr(s_addr), .s_write(s_write), .s_wdata(s_wdata),
        .addr_owner(addr_owner), .data_owner(data_owner)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [1:0] o);
        return (o == 2'b01) ? A1 : (o == 2'b10) ? A2 : '0;
    endfunction

    function automatic logic [DW-1:0] exp_data(input logic [1:0] o);
        return (o == 2'b01) ? D1 : (o == 2'b10) ? D2 : '0;
    endfunction

    task automatic check_outputs(input logic [1:0] eao, input logic [1:0] edo);
        chk("R5 addr_owner", 64'(addr_owner), 64'(eao));
        chk("R6 data_owner", 64'(data_owner), 64'(edo));
        chk("R9 s_addr", 64'(s_addr), 64'(exp_addr(eao)));
        chk("R9 s_write", 64'(s_write), 64'(eao == 2'b01));
        chk("R6 s_wdata", 64'(s_wdata), 64'(exp_data(edo)));
    endtask

    task automatic step(input logic [8:0] v);
        @(negedge clk);
        m1_req = v[8]; m2_req = v[7]; s_ready = v[6];
        #2;
        chk("R2/R3/R4/R7 grant", 64'({m2_grant, m1_grant}), 64'(v[5:4]));
        @(posedge clk);
        #2;
        check_outputs(v[3:2], v[1:0]);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset with both requests high
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 grants in reset", 64'({m2_grant, m1_grant}), 64'd0);
        check_outputs(2'b00, 2'b00);
        rst = 1'b0;
        m1_req = 1'b0; m2_req = 1'b0;

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R1: reset mid-run clears ownership
        step({3'b101, 2'b01, 2'b01, 2'b00});
        step({3'b101, 2'b01, 2'b01, 2'b01});
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 grants mid reset", 64'({m2_grant, m1_grant}), 64'd0);
        check_outputs(2'b00, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        m1_req = 1'b0;

        // R7: stall right after grant of m2 keeps data owner idle
        step({3'b011, 2'b10, 2'b10, 2'b00});
        step({3'b000, 2'b10, 2'b10, 2'b00});
        step({3'b001, 2'b00, 2'b00, 2'b10});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule